// File: doc/BRIEF.md
# Indexed Vector Load Address Checker

This block sits in the address path of a vector load unit that serves unordered indexed loads. When an operation is accepted, it captures a scalar base address, the program counter of the load, an element-width code, the vector length, an optional mask and a vector of per-element byte offsets. It then walks the elements in ascending order. For each active element, it adds the offset to the base and checks the sum against the natural alignment of the element width.

Aligned elements become memory requests under a valid/ready handshake. The first misaligned active element stops the walk. It raises a precise trap with the load-address-misaligned cause code. The trap report carries the full faulting address, the element number and the program counter of the load. The trap report stays up until the trap handler acknowledges it.

Top module: `vidx_ld_agu`

## Requirements
- R1: The address of element i is `base + idx_vec[i*XLEN +: XLEN]`, taken modulo 2^XLEN. The offset is an unscaled byte offset.
- R2: The element-width code `ew` sets the alignment rule. Code 0 is 8-bit data, with no alignment rule. Code 1 is 16-bit data, and address bit 0 must be zero. Code 2 is 32-bit data, and bits 1:0 must be zero. Code 3 is 64-bit data, and bits 2:0 must be zero.
- R3: A misaligned active element raises `trap_valid` with `trap_cause` equal to 4 (load address misaligned), never 2 (illegal instruction). `trap_tval` equals the full faulting address.
- R4: `trap_elem` is the number of the faulting element. It is 0 when element 0 faults. `trap_epc` is the `pc` captured when the operation started.
- R5: After a fault, no request is issued for the faulting element or for any later element.
- R6: When `mask_en` is 1, an element whose `mask` bit is 0 is skipped. A skipped element never traps and is never requested. When `mask_en` is 0, every element below `vl` is active.
- R7: Processing starts at element `vstart` and proceeds in strictly ascending element order. Elements below `vstart` are neither requested nor checked.
- R8: Each aligned active element produces exactly one request. While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_elem` hold steady.
- R9: When the walk ends without a fault, `done` pulses for one cycle and no trap is raised. If `vl` is not greater than `vstart`, the block pulses `done` and issues no request.
- R10: The trap outputs hold their values until `trap_ack` clears `trap_valid`. A `start` is ignored while a trap is pending or while the block is busy.
- R11: After reset, `busy`, `req_valid`, `done` and `trap_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept a new operation (when idle and no trap is pending) |
| base | input | XLEN | Scalar base address |
| pc | input | XLEN | Address of the load instruction |
| ew | input | 2 | Element-width code: 0/1/2/3 = 8/16/32/64 bits |
| vl | input | EIDX_W | Vector length |
| vstart | input | EIDX_W | First element to process |
| mask_en | input | 1 | 1 = apply `mask`; 0 = all elements active |
| mask | input | MAXVL | Per-element active bits |
| idx_vec | input | MAXVL*XLEN | Byte offsets; element i at bits [i*XLEN +: XLEN] |
| busy | output | 1 | An operation is being walked |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | XLEN | Request address |
| req_elem | output | EIDX_W | Element number of the request |
| done | output | 1 | One-cycle pulse: finished without a trap |
| trap_valid | output | 1 | Trap pending |
| trap_cause | output | 6 | Exception cause code |
| trap_tval | output | XLEN | Faulting address |
| trap_elem | output | EIDX_W | Faulting element number |
| trap_epc | output | XLEN | Program counter of the faulting load |
| trap_ack | input | 1 | Clears the pending trap |

## Verification
The first test is a misaligned first element with a nonzero base. A design that reports the wrong class of trap, or that zeroes the trap value, fails the cause and tval comparisons.

Other tests place the fault at a middle element and at an address that wraps past the top of the address space. These catch a wrong element number, a truncated address and requests that leak past the fault.

Masked-off misaligned elements, a nonzero start element and an empty range check that skipped elements neither trap nor issue. Width codes 8 and 64 check the alignment masks at both ends. Random-phase backpressure and repeated starts while a trap is pending show whether a design drops or moves a stalled request, or overwrites a held trap.

// File: rtl/vidx_pkg.sv
// Shared types and constants for the indexed load address checker.
package vidx_pkg;

    typedef enum logic [1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } ew_e;

    localparam int CAUSE_W = 6;
    localparam logic [CAUSE_W-1:0] CAUSE_LOAD_MISALIGN = 6'd4;

    // Low address bits that must be zero for a given element width.
    function automatic logic [2:0] align_mask(input ew_e w);
        case (w)
            EW_8:    align_mask = 3'b000;
            EW_16:   align_mask = 3'b001;
            EW_32:   align_mask = 3'b011;
            default: align_mask = 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/vidx_op_latch.sv
// Operand capture register.
// Holds the operands of one indexed load from acceptance until the next one.
// Assumes: accept is a single-cycle strobe issued only when the block is idle.
module vidx_op_latch #(
    parameter int XLEN   = 32,
    parameter int MAXVL  = 8,
    parameter int EIDX_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accept,
    input  logic [XLEN-1:0]       base,
    input  logic [XLEN-1:0]       pc,
    input  logic [1:0]            ew,
    input  logic [EIDX_W-1:0]     vl,
    input  logic                  mask_en,
    input  logic [MAXVL-1:0]      mask,
    input  logic [MAXVL*XLEN-1:0] idx_vec,
    output logic [XLEN-1:0]       base_q,
    output logic [XLEN-1:0]       pc_q,
    output logic [1:0]            ew_q,
    output logic [EIDX_W-1:0]     vl_q,
    output logic                  mask_en_q,
    output logic [MAXVL-1:0]      mask_q,
    output logic [MAXVL*XLEN-1:0] idx_q
);

    // Scalar operands: loaded on accept, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            pc_q      <= '0;
            ew_q      <= '0;
            vl_q      <= '0;
            mask_en_q <= 1'b0;
            mask_q    <= '0;
        end else if (accept) begin
            base_q    <= base;
            pc_q      <= pc;
            ew_q      <= ew;
            vl_q      <= vl;
            mask_en_q <= mask_en;
            mask_q    <= mask;
        end
    end

    // One offset register per element.
    for (genvar g = 0; g < MAXVL; g++) begin : g_idx
        always_ff @(posedge clk) begin
            if (!rst_n)
                idx_q[g*XLEN +: XLEN] <= '0;
            else if (accept)
                idx_q[g*XLEN +: XLEN] <= idx_vec[g*XLEN +: XLEN];
        end
    end

endmodule

// File: rtl/vidx_addr_calc.sv
// Effective address and alignment check for the selected element.
// Purely combinational.
// Assumes: XLEN >= 3, and sel < MAXVL whenever the result is used.
module vidx_addr_calc
    import vidx_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int MAXVL = 8,
    parameter int SEL_W = 3
) (
    input  logic [XLEN-1:0]       base_q,
    input  logic [MAXVL*XLEN-1:0] idx_q,
    input  logic [1:0]            ew_q,
    input  logic [SEL_W-1:0]      sel,
    output logic [XLEN-1:0]       addr,
    output logic                  misaligned
);

    logic [XLEN-1:0] offs [MAXVL];

    // Split the flat offset vector into elements.
    for (genvar g = 0; g < MAXVL; g++) begin : g_split
        assign offs[g] = idx_q[g*XLEN +: XLEN];
    end

    // Unscaled byte offset added to base; alignment from width code.
    always_comb begin
        addr       = base_q + offs[sel];
        misaligned = |(addr[2:0] & align_mask(ew_e'(ew_q)));
    end

endmodule

// File: rtl/vidx_elem_seq.sv
// Element walker.
// Steps a cursor from vstart to vl, skips inactive elements, issues aligned
// active elements under valid/ready, and stops at the first misaligned one.
// Assumes: misaligned refers to the element at the current cursor.
module vidx_elem_seq #(
    parameter int MAXVL  = 8,
    parameter int EIDX_W = 4,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              trap_pending,
    input  logic [EIDX_W-1:0] vstart_in,
    input  logic [EIDX_W-1:0] vl_q,
    input  logic              mask_en_q,
    input  logic [MAXVL-1:0]  mask_q,
    input  logic              misaligned,
    input  logic              req_ready,
    output logic              accept,
    output logic              busy,
    output logic              req_valid,
    output logic              fault,
    output logic              done,
    output logic [EIDX_W-1:0] cursor
);

    logic busy_q;
    logic done_q;
    logic in_range;
    logic active;
    logic finish;
    logic advance;

    // Classify the element under the cursor.
    always_comb begin
        in_range  = busy_q && (cursor < vl_q);
        active    = in_range && (!mask_en_q || mask_q[cursor[SEL_W-1:0]]);
        req_valid = active && !misaligned;
        fault     = active && misaligned;
        finish    = busy_q && !in_range;
        advance   = (in_range && !active) || (req_valid && req_ready);
        accept    = start && !busy_q && !trap_pending;
    end

    // Walk state and cursor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cursor <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cursor <= vstart_in;
        end else if (finish || fault) begin
            busy_q <= 1'b0;
        end else if (advance) begin
            cursor <= cursor + 1'b1;
        end
    end

    // One-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= finish;
    end

    assign busy = busy_q;
    assign done = done_q;

endmodule

// File: rtl/vidx_trap_reg.sv
// Trap report register.
// Captures cause, address, element and pc on a fault and holds them until
// acknowledged.
// Assumes: no fault arrives while a trap is pending.
module vidx_trap_reg
    import vidx_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int EIDX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fault,
    input  logic               ack,
    input  logic [XLEN-1:0]    addr,
    input  logic [EIDX_W-1:0]  elem,
    input  logic [XLEN-1:0]    epc,
    output logic               trap_valid,
    output logic [CAUSE_W-1:0] trap_cause,
    output logic [XLEN-1:0]    trap_tval,
    output logic [EIDX_W-1:0]  trap_elem,
    output logic [XLEN-1:0]    trap_epc
);

    // Load on fault, clear on acknowledge, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n || ack) begin
            trap_valid <= 1'b0;
            trap_cause <= '0;
            trap_tval  <= '0;
            trap_elem  <= '0;
            trap_epc   <= '0;
        end else if (fault) begin
            trap_valid <= 1'b1;
            trap_cause <= CAUSE_LOAD_MISALIGN;
            trap_tval  <= addr;
            trap_elem  <= elem;
            trap_epc   <= epc;
        end
    end

endmodule

// File: rtl/vidx_ld_agu.sv
// Indexed load address checker (top).
// Forms per-element addresses, checks alignment, issues requests and
// reports a precise misaligned-load trap.
// Assumes: MAXVL is a power of two, and offsets are byte offsets.
module vidx_ld_agu
    import vidx_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int MAXVL  = 8,
    localparam int EIDX_W = $clog2(MAXVL + 1),
    localparam int SEL_W  = (MAXVL > 1) ? $clog2(MAXVL) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [XLEN-1:0]       base,
    input  logic [XLEN-1:0]       pc,
    input  logic [1:0]            ew,
    input  logic [EIDX_W-1:0]     vl,
    input  logic [EIDX_W-1:0]     vstart,
    input  logic                  mask_en,
    input  logic [MAXVL-1:0]      mask,
    input  logic [MAXVL*XLEN-1:0] idx_vec,
    output logic                  busy,
    output logic                  req_valid,
    input  logic                  req_ready,
    output logic [XLEN-1:0]       req_addr,
    output logic [EIDX_W-1:0]     req_elem,
    output logic                  done,
    output logic                  trap_valid,
    output logic [CAUSE_W-1:0]    trap_cause,
    output logic [XLEN-1:0]       trap_tval,
    output logic [EIDX_W-1:0]     trap_elem,
    output logic [XLEN-1:0]       trap_epc,
    input  logic                  trap_ack
);

    logic                  accept;
    logic                  fault;
    logic                  misaligned;
    logic [XLEN-1:0]       addr;
    logic [EIDX_W-1:0]     cursor;
    logic [XLEN-1:0]       base_q;
    logic [XLEN-1:0]       pc_q;
    logic [1:0]            ew_q;
    logic [EIDX_W-1:0]     vl_q;
    logic                  mask_en_q;
    logic [MAXVL-1:0]      mask_q;
    logic [MAXVL*XLEN-1:0] idx_q;

    vidx_op_latch #(.XLEN(XLEN), .MAXVL(MAXVL), .EIDX_W(EIDX_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .base(base), .pc(pc), .ew(ew), .vl(vl), .mask_en(mask_en),
        .mask(mask), .idx_vec(idx_vec),
        .base_q(base_q), .pc_q(pc_q), .ew_q(ew_q), .vl_q(vl_q),
        .mask_en_q(mask_en_q), .mask_q(mask_q), .idx_q(idx_q)
    );

    vidx_addr_calc #(.XLEN(XLEN), .MAXVL(MAXVL), .SEL_W(SEL_W)) u_addr (
        .base_q(base_q), .idx_q(idx_q), .ew_q(ew_q),
        .sel(cursor[SEL_W-1:0]), .addr(addr), .misaligned(misaligned)
    );

    vidx_elem_seq #(.MAXVL(MAXVL), .EIDX_W(EIDX_W), .SEL_W(SEL_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .trap_pending(trap_valid),
        .vstart_in(vstart), .vl_q(vl_q), .mask_en_q(mask_en_q),
        .mask_q(mask_q), .misaligned(misaligned), .req_ready(req_ready),
        .accept(accept), .busy(busy), .req_valid(req_valid), .fault(fault),
        .done(done), .cursor(cursor)
    );

    vidx_trap_reg #(.XLEN(XLEN), .EIDX_W(EIDX_W)) u_trap (
        .clk(clk), .rst_n(rst_n), .fault(fault), .ack(trap_ack),
        .addr(addr), .elem(cursor), .epc(pc_q),
        .trap_valid(trap_valid), .trap_cause(trap_cause),
        .trap_tval(trap_tval), .trap_elem(trap_elem), .trap_epc(trap_epc)
    );

    assign req_addr = addr;
    assign req_elem = cursor;

endmodule

// File: rtl/vidx_ld_agu_chk.sv
// Property checker for vidx_ld_agu, attached with bind.
module vidx_ld_agu_chk
    import vidx_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int EIDX_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               req_valid,
    input logic               req_ready,
    input logic [XLEN-1:0]    req_addr,
    input logic [EIDX_W-1:0]  req_elem,
    input logic               done,
    input logic               trap_valid,
    input logic [CAUSE_W-1:0] trap_cause,
    input logic [XLEN-1:0]    trap_tval,
    input logic [EIDX_W-1:0]  trap_elem,
    input logic               trap_ack,
    input logic [1:0]         ew_q
);

    // R2
    req_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((req_addr[2:0] & align_mask(ew_e'(ew_q))) == 3'b000));

    // R3
    trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> trap_cause == CAUSE_LOAD_MISALIGN);

    // R5
    no_req_after_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> !req_valid);

    // R7
    ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_valid || req_elem > $past(req_elem)));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=>
            (req_valid && $stable(req_addr) && $stable(req_elem)));

    // R9
    done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!trap_valid && !busy));

    // R10
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && !trap_ack) |=>
            (trap_valid && $stable(trap_tval) && $stable(trap_elem) && $stable(trap_cause)));

    // R11
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !req_valid && !done && !trap_valid));

endmodule

bind vidx_ld_agu vidx_ld_agu_chk #(.XLEN(XLEN), .EIDX_W(EIDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_elem(req_elem),
    .done(done), .trap_valid(trap_valid), .trap_cause(trap_cause),
    .trap_tval(trap_tval), .trap_elem(trap_elem), .trap_ack(trap_ack),
    .ew_q(ew_q)
);

// File: tb/vidx_ld_agu_tb.sv
module vidx_ld_agu_tb;
    localparam int XL = 32;
    localparam int NV = 8;
    localparam int EW_ = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [XL-1:0]    base = '0;
    logic [XL-1:0]    pc = '0;
    logic [1:0]       ew = '0;
    logic [EW_-1:0]   vl = '0;
    logic [EW_-1:0]   vstart = '0;
    logic             mask_en = 1'b0;
    logic [NV-1:0]    mask = '0;
    logic [NV*XL-1:0] idx_vec = '0;
    logic             busy, req_valid, done, trap_valid;
    logic             req_ready = 1'b1;
    logic [XL-1:0]    req_addr, trap_tval, trap_epc;
    logic [EW_-1:0]   req_elem, trap_elem;
    logic [5:0]       trap_cause;
    logic             trap_ack = 1'b0;

    vidx_ld_agu #(.XLEN(XL), .MAXVL(NV)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base(base), .pc(pc),
        .ew(ew), .vl(vl), .vstart(vstart), .mask_en(mask_en), .mask(mask),
        .idx_vec(idx_vec), .busy(busy), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_elem(req_elem),
        .done(done), .trap_valid(trap_valid), .trap_cause(trap_cause),
        .trap_tval(trap_tval), .trap_elem(trap_elem), .trap_epc(trap_epc),
        .trap_ack(trap_ack)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Capture of completed handshakes, sampled 5 ns after the falling edge.
    logic [XL-1:0]  cap_addr [16];
    logic [EW_-1:0] cap_elem [16];
    int             n_cap = 0;
    bit             done_seen = 0;
    bit             stall_prev = 0;
    logic [XL-1:0]  stall_addr;
    logic [EW_-1:0] stall_elem;
    bit             stall_mode = 0;
    int             cyc = 0;

    always @(negedge clk) begin
        cyc++;
        req_ready <= stall_mode ? (cyc % 3 == 0) : 1'b1;
    end

    always begin
        @(negedge clk);
        #5;
        if (rst_n) begin
            if (stall_prev) begin
                chk("R8 stalled request stays valid", req_valid, 1);
                chk("R8 stalled address steady", req_addr, stall_addr);
                chk("R8 stalled element steady", req_elem, stall_elem);
            end
            stall_prev = req_valid && !req_ready;
            stall_addr = req_addr;
            stall_elem = req_elem;
            if (req_valid && req_ready) begin
                if (n_cap < 16) begin
                    cap_addr[n_cap] = req_addr;
                    cap_elem[n_cap] = req_elem;
                end
                n_cap++;
            end
            if (done) done_seen = 1;
        end
    end

    // Drive one operation, wait for its end and compare against the rules.
    task automatic run_op(input logic [XL-1:0] b, input logic [XL-1:0] p,
                          input logic [1:0] w, input int l, input int vs,
                          input logic me, input logic [NV-1:0] m,
                          input logic [NV*XL-1:0] iv);
        logic [2:0]    am;
        logic [XL-1:0] a;
        logic [XL-1:0] exp_addr [NV];
        int            exp_elem [NV];
        int            exp_n = 0;
        bit            exp_trap = 0;
        int            exp_te = 0;
        logic [XL-1:0] exp_tv = '0;
        @(negedge clk);
        base = b; pc = p; ew = w; vl = EW_'(l); vstart = EW_'(vs);
        mask_en = me; mask = m; idx_vec = iv; start = 1'b1;
        n_cap = 0; done_seen = 0;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            #6;
            if (done_seen || trap_valid) break;
        end
        am = (w == 2'd0) ? 3'd0 : (w == 2'd1) ? 3'd1 : (w == 2'd2) ? 3'd3 : 3'd7;
        for (int i = vs; i < l; i++) begin
            if (me && !m[i]) continue;
            a = b + iv[i*XL +: XL];
            if ((a[2:0] & am) != 0) begin
                exp_trap = 1; exp_te = i; exp_tv = a;
                break;
            end
            exp_addr[exp_n] = a;
            exp_elem[exp_n] = i;
            exp_n++;
        end
        // R5 R6 R7: request count reflects skips, start point and stop at fault
        chk("R5 R6 R7 request count", n_cap, exp_n);
        for (int i = 0; i < exp_n && i < n_cap; i++) begin
            chk("R1 request address", cap_addr[i], exp_addr[i]);
            chk("R7 request element", cap_elem[i], exp_elem[i]);
        end
        chk("R2 R3 trap raised", trap_valid, exp_trap);
        if (exp_trap) begin
            chk("R3 cause is misaligned load", trap_cause, 4);
            chk("R3 trap value is fault address", trap_tval, exp_tv);
            chk("R4 faulting element", trap_elem, exp_te);
            chk("R4 trap pc", trap_epc, p);
        end else begin
            chk("R9 done pulse seen", done_seen, 1);
        end
    endtask

    task automatic ack_trap();
        @(negedge clk);
        trap_ack = 1'b1;
        @(negedge clk);
        trap_ack = 1'b0;
        #6;
        chk("R10 ack clears trap", trap_valid, 0);
    endtask

    function automatic logic [NV*XL-1:0] pack4(input logic [XL-1:0] a0, input logic [XL-1:0] a1,
                                               input logic [XL-1:0] a2, input logic [XL-1:0] a3);
        logic [NV*XL-1:0] v = '0;
        v[0*XL +: XL] = a0; v[1*XL +: XL] = a1; v[2*XL +: XL] = a2; v[3*XL +: XL] = a3;
        return v;
    endfunction

    task automatic t_reset();
        repeat (3) @(negedge clk);
        #5;
        // R11
        chk("R11 busy after reset", busy, 0);
        chk("R11 req_valid after reset", req_valid, 0);
        chk("R11 done after reset", done, 0);
        chk("R11 trap_valid after reset", trap_valid, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_aligned();
        run_op(32'h0000_1000, 32'h100, 2'd2, 4, 0, 1'b0, '0, pack4(0, 4, 8, 12));
    endtask

    task automatic t_first_fault_and_hold();
        logic [XL-1:0] tv;
        // R3 R4: fault on element 0 with a nonzero base
        run_op(32'h8000_00c0, 32'h8000_0048, 2'd2, 4, 0, 1'b0, '0, pack4(1, 4, 8, 12));
        tv = trap_tval;
        repeat (4) @(negedge clk);
        #6;
        chk("R10 trap still valid", trap_valid, 1);
        chk("R10 trap value held", trap_tval, tv);
        @(negedge clk);
        n_cap = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        #6;
        chk("R10 start ignored while trap pending", n_cap, 0);
        chk("R10 not busy while trap pending", busy, 0);
        chk("R10 trap value unchanged", trap_tval, 32'h8000_00c1);
        ack_trap();
    endtask

    task automatic t_mid_fault();
        logic [NV*XL-1:0] v = pack4(0, 2, 5, 6);
        v[4*XL +: XL] = 8;
        run_op(32'h0000_2000, 32'h200, 2'd1, 5, 0, 1'b0, '0, v);
        ack_trap();
    endtask

    task automatic t_mask();
        logic [NV*XL-1:0] v = pack4(0, 3, 8, 12);
        v[4*XL +: XL] = 16;
        // R6: masked-off misaligned element 1 is skipped
        run_op(32'h0000_3000, 32'h300, 2'd2, 5, 0, 1'b1, 8'b0001_1101, v);
        // R6: same offsets with the mask disabled fault on element 1
        run_op(32'h0000_3000, 32'h304, 2'd2, 5, 0, 1'b0, 8'b0001_1101, v);
        ack_trap();
    endtask

    task automatic t_vstart();
        // R7: misaligned elements below vstart are not checked
        run_op(32'h0000_4000, 32'h400, 2'd2, 4, 2, 1'b0, '0, pack4(1, 2, 8, 12));
    endtask

    task automatic t_widths();
        // R2: byte width never faults
        run_op(32'h0000_5001, 32'h500, 2'd0, 4, 0, 1'b0, '0, pack4(0, 2, 4, 6));
        // R2: 64-bit width faults on a 4-byte offset
        run_op(32'h0000_6000, 32'h600, 2'd3, 3, 0, 1'b0, '0, pack4(0, 8, 4, 0));
        ack_trap();
        // R1: address wraps modulo 2^XLEN
        run_op(32'hFFFF_FFF0, 32'h700, 2'd1, 2, 0, 1'b0, '0, pack4(32'h10, 32'h13, 0, 0));
        ack_trap();
    endtask

    task automatic t_stall();
        logic [NV*XL-1:0] v = pack4(0, 2, 4, 6);
        v[4*XL +: XL] = 10; v[5*XL +: XL] = 12;
        stall_mode = 1;
        run_op(32'h0000_8000, 32'h800, 2'd1, 6, 0, 1'b0, '0, v);
        stall_mode = 0;
    endtask

    task automatic t_empty();
        // R9: empty ranges finish with no requests
        run_op(32'h0000_9000, 32'h900, 2'd2, 0, 0, 1'b0, '0, pack4(1, 1, 1, 1));
        run_op(32'h0000_9000, 32'h904, 2'd2, 3, 3, 1'b0, '0, pack4(1, 1, 1, 1));
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_aligned();
        t_first_fault_and_hold();
        t_mid_fault();
        t_mask();
        t_vstart();
        t_widths();
        t_stall();
        t_empty();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule